// File: doc/BRIEF.md
# Free-Running Timer with Edge Capture

This block holds a 12-bit counter that never stops. It advances once on each system-clock cycle in which a 1 MHz step enable is high. Two periodic pulses come from it. A fast pulse fires every 128 counts, which is 128 µs at 1 MHz. A slow pulse fires every 1024 counts, which is 1.024 ms. Software reads the live count whenever it likes and measures an interval as the difference of two readings. The counter rolls over with no penalty.

Two capture channels watch asynchronous input pins. Each channel first passes its pin through a two-flop synchroniser. On the edge polarity that software selects, the channel copies the current count into its own capture register and raises a one-cycle interrupt pulse. A later capture replaces the stored value, whether or not software has read it.

Top module: `frc_capture`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the count, both capture registers, both tick pulses and both interrupt pulses are zero.
- R2: After each clock edge at which `tick_en` is high, the count is one greater. After an edge at which `tick_en` is low, the count is unchanged.
- R3: An enabled step from 0xFFF gives 0x000. The counter keeps stepping afterwards without pausing.
- R4: `tick_fast` is high for exactly one cycle. That cycle is the one in which the count has just been stepped onto a value whose low 7 bits are zero. It is low in every other cycle.
- R5: `tick_slow` is high for exactly one cycle. That cycle is the one in which the count has just been stepped onto a value whose low 10 bits are zero. It is low in every other cycle.
- R6: Each channel selects its capture edge with bit i of `cap_rise`: 1 selects rising and 0 selects falling. A pin change made between two clock edges is captured at the third rising clock edge after it. The stored value is the count shown in the cycle just before that edge.
- R7: Bit i of `cap_irq` is high for exactly the one cycle in which channel i's capture register has just been loaded.
- R8: A pin edge of the polarity that is not selected changes neither the capture register nor `cap_irq`.
- R9: A second capture overwrites the first. No read is required in between.
- R10: The channels are independent. Slice i of `cap_val` (bits i*12 to i*12+11) belongs to pin i only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 1 MHz step enable, one clock wide |
| cap_in | input | 2 | Asynchronous capture pins |
| cap_rise | input | 2 | Per-channel edge select (1 rising, 0 falling) |
| count | output | 12 | Live counter value |
| tick_fast | output | 1 | Pulse every 128 counts |
| tick_slow | output | 1 | Pulse every 1024 counts |
| cap_val | output | 24 | Capture registers, channel i in bits i*12 +: 12 |
| cap_irq | output | 2 | Per-channel capture pulse |

## Verification
The bench builds the block with its default parameters: a 12-bit counter, taps at 128 and 1024 counts, and two channels. With `tick_en` held high, one full period of the counter takes only 4096 cycles. This makes a complete sweep of every count value, including the roll-over, cheap enough to run. A second phase drives the enable sparsely. The capture sweep then covers every channel, both edge selections, and both pin directions at several spacings.

// File: rtl/frc_capture.sv
module frc_capture #(
  parameter int CNT_W    = 12,
  parameter int FAST_BIT = 7,
  parameter int SLOW_BIT = 10,
  parameter int NCAP     = 2,
  parameter int SYNC_N   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  input  logic [NCAP-1:0]       cap_in,
  input  logic [NCAP-1:0]       cap_rise,
  output logic [CNT_W-1:0]      count,
  output logic                  tick_fast,
  output logic                  tick_slow,
  output logic [NCAP*CNT_W-1:0] cap_val,
  output logic [NCAP-1:0]       cap_irq
);

  logic [CNT_W-1:0] cnt;

  assign count = cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      tick_fast <= 1'b0;
      tick_slow <= 1'b0;
    end else begin
      if (tick_en) cnt <= cnt + 1'b1;
      tick_fast <= tick_en & (&cnt[FAST_BIT-1:0]);
      tick_slow <= tick_en & (&cnt[SLOW_BIT-1:0]);
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt == $past(cnt) + 1'b1);
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));
  // R4
  fast_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fast |-> cnt[FAST_BIT-1:0] == '0);
  // R5
  slow_in_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_slow |-> tick_fast);

  for (genvar i = 0; i < NCAP; i++) begin : g_cap
    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic              lvl, hit;

    assign lvl = sync_q[SYNC_N-1];
    assign hit = cap_rise[i] ? (lvl & ~prev_q) : (~lvl & prev_q);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sync_q                  <= '0;
        prev_q                  <= 1'b0;
        cap_irq[i]              <= 1'b0;
        cap_val[i*CNT_W +: CNT_W] <= '0;
      end else begin
        sync_q     <= {sync_q[SYNC_N-2:0], cap_in[i]};
        prev_q     <= lvl;
        cap_irq[i] <= hit;
        if (hit) cap_val[i*CNT_W +: CNT_W] <= cnt;
      end
    end

    // R6
    cap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_irq[i] |-> cap_val[i*CNT_W +: CNT_W] == $past(cnt));
    // R7
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_irq[i] |=> !cap_irq[i]);
    // R8
    cap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_irq[i] |-> $stable(cap_val[i*CNT_W +: CNT_W]));
  end

endmodule

// File: tb/frc_capture_tb.sv
module frc_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [1:0]  cap_in = 2'b00;
  logic [1:0]  cap_rise = 2'b00;
  logic [11:0] count;
  logic        tick_fast, tick_slow;
  logic [23:0] cap_val;
  logic [1:0]  cap_irq;

  int checks = 0;
  int errors = 0;
  logic        mon_on = 1'b0;
  logic [11:0] ref_cnt = '0;
  logic        adv = 1'b0;

  always #5 clk = ~clk;

  frc_capture u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cap_in(cap_in),
    .cap_rise(cap_rise), .count(count), .tick_fast(tick_fast),
    .tick_slow(tick_slow), .cap_val(cap_val), .cap_irq(cap_irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      adv     <= 1'b0;
    end else begin
      if (tick_en) ref_cnt <= ref_cnt + 12'd1;
      adv <= tick_en;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      chk("R2 count", {20'd0, count}, {20'd0, ref_cnt});
      chk("R4 tick_fast", {31'd0, tick_fast}, {31'd0, adv && ref_cnt[6:0] == 7'd0});
      chk("R5 tick_slow", {31'd0, tick_slow}, {31'd0, adv && ref_cnt[9:0] == 10'd0});
      if (adv && ref_cnt == 12'd0)
        chk("R3 wrap", {20'd0, count}, 32'd0);
    end
  end

  function automatic logic [11:0] slice(input int ch);
    return cap_val[ch*12 +: 12];
  endfunction

  task automatic cap_step(input int ch, input logic lvl, input logic expect_hit, input string req);
    logic [11:0] exp_v, other_v, old_v;
    old_v   = slice(ch);
    other_v = slice(1 - ch);
    cap_in[ch] = lvl;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    exp_v = expect_hit ? ref_cnt : old_v;
    @(posedge clk); @(negedge clk);
    chk(req, {20'd0, slice(ch)}, {20'd0, exp_v});
    chk("R7 irq pulse", {31'd0, cap_irq[ch]}, {31'd0, expect_hit});
    chk("R10 other channel", {20'd0, slice(1 - ch)}, {20'd0, other_v});
    chk("R10 other irq", {31'd0, cap_irq[1 - ch]}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R7 irq one cycle", {31'd0, cap_irq[ch]}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count", {20'd0, count}, 32'd0);
    chk("R1 cap_val", {8'd0, cap_val}, 32'd0);
    chk("R1 ticks", {30'd0, tick_fast, tick_slow}, 32'd0);
    chk("R1 irq", {30'd0, cap_irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {20'd0, count}, 32'd0);
    mon_on = 1'b1;

    tick_en = 1'b1;
    repeat (4300) @(negedge clk);

    for (int k = 0; k < 3300; k++) begin
      tick_en = (k % 3 == 0);
      @(negedge clk);
    end
    tick_en = 1'b0;
    repeat (5) @(negedge clk);
    chk("R2 hold", {20'd0, count}, {20'd0, ref_cnt});

    tick_en = 1'b1;
    for (int sel = 0; sel < 2; sel++) begin
      for (int ch = 0; ch < 2; ch++) begin
        cap_rise[ch] = sel[0];
        repeat (2) @(negedge clk);
        for (int rep = 0; rep < 3; rep++) begin
          if (sel == 1) begin
            cap_step(ch, 1'b1, 1'b1, "R6 rising capture");
            repeat (rep * 7 + 3) @(negedge clk);
            cap_step(ch, 1'b0, 1'b0, "R8 falling ignored");
          end else begin
            cap_step(ch, 1'b1, 1'b0, "R8 rising ignored");
            repeat (rep * 5 + 2) @(negedge clk);
            cap_step(ch, 1'b0, 1'b1, rep == 0 ? "R6 falling capture" : "R9 overwrite");
          end
          repeat (rep * 11 + 4) @(negedge clk);
        end
      end
    end

    cap_rise = 2'b11;
    repeat (3) @(negedge clk);
    cap_step(0, 1'b1, 1'b1, "R9 overwrite ch0");
    repeat (9) @(negedge clk);
    cap_step(0, 1'b0, 1'b0, "R8 ch0 fall");
    cap_step(0, 1'b1, 1'b1, "R9 overwrite ch0 again");

    mon_on = 1'b0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule